// File: doc/BRIEF.md
# Command Register Reset Controller

This block interprets command words written to the command register of a control port. Each word packs a command type and a 3-bit operand. The commands can clear the pointer sets of either queue direction, clear the DMA request logic, choose which of eight configuration registers is addressed, set the DMA transfer direction, and pick the status presentation format. Clears leave the block as single-cycle strobes that the queue datapath and the DMA handshake logic consume. The block also holds the bank of eight configuration registers, so that it can put them back to their default values.

A hardware reset and a software "reset all" command restore different sets of state. Both clear every pointer and the DMA request logic, and both restore the configuration defaults. Only the hardware reset also returns the DMA direction, the status format and the selected register index to zero. Only the hardware reset raises a separate strobe that clears the odd-byte valid bit and the parity error latches downstream.

Top module: `cmdrst_ctrl`

## Requirements
- R1: A command word is taken on a rising clock edge only while `cmd_valid` is high. Its type sits in bits [5:3] and its operand in bits [2:0]. The types are 000 reset, 001 select configuration register, 010 DMA direction and 011 status format. Every effect appears on the outputs in the cycle after that edge.
- R2: Reset operand 001 pulses `clr_ba_ptr` for exactly one cycle and raises no other strobe.
- R3: Reset operand 010 pulses `clr_ab_ptr` alone. Reset operand 011 pulses `clr_ba_ptr` and `clr_ab_ptr` together. Each pulse lasts one cycle.
- R4: Reset operand 100 pulses `clr_dma_req` alone, for one cycle.
- R5: Reset operands 000, 101 and 110 raise no strobe and change no held state.
- R6: Reset operand 111 pulses `clr_ba_ptr`, `clr_ab_ptr` and `clr_dma_req` for one cycle. It returns configuration register 4 to 16'h6420 and all other configuration registers to 0. It leaves `cfg_sel`, `dma_dir` and `stat_fmt` unchanged and does not raise `hw_clr`.
- R7: The select command loads its operand into `cfg_sel`. `cfg_rdata` shows the selected register. A `cfg_wr` pulse writes `cfg_wdata` into the register selected at that edge.
- R8: While `periph_mode` is high, the DMA direction command sets `dma_dir` to operand bit 0 (0 = BA write, 1 = AB read). While `periph_mode` is low, the command is ignored.
- R9: The status format command sets `stat_fmt` to operand bit 0 (0 = format 0, 1 = format 1).
- R10: While `rst_n` is low, and until the first clock edge after it is released, the outputs `clr_ba_ptr`, `clr_ab_ptr`, `clr_dma_req` and `hw_clr` are all high. During hardware reset `cfg_sel`, `dma_dir` and `stat_fmt` are 0 and the configuration registers hold their defaults.
- R11: Command types 100 to 111 raise no strobe and change no held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| cmd_valid | input | 1 | Command write strobe, one cycle per command |
| cmd_word | input | 6 | Command type [5:3] and operand [2:0] |
| periph_mode | input | 1 | Enables the DMA direction command |
| cfg_wr | input | 1 | Write strobe for the selected configuration register |
| cfg_wdata | input | 16 | Configuration write data |
| clr_ba_ptr | output | 1 | Clear strobe for the B-to-A pointers, including the rewrite pointer |
| clr_ab_ptr | output | 1 | Clear strobe for the A-to-B pointers, including the reread pointer |
| clr_dma_req | output | 1 | Clear strobe for the DMA request logic |
| hw_clr | output | 1 | Hardware-reset-only clear for the odd-byte valid bit and parity errors |
| cfg_sel | output | 3 | Selected configuration register index |
| dma_dir | output | 1 | DMA direction: 0 BA write, 1 AB read |
| stat_fmt | output | 1 | Status format select |
| cfg_rdata | output | 16 | Contents of the selected configuration register |

## Verification
A wrong decode shows at the ports one cycle after the command edge. The error is either the wrong set of strobes or a strobe that stays high into a second cycle. The bench therefore samples every command twice: once in the cycle after it and once in the cycle after that. Corrupted held state is quieter. A stale direction, format or index shows up only at the next command that should leave it untouched. A configuration restore that misses a register shows up only when that register is selected. For that reason the bench selects and reads registers back after each reset kind.

// File: rtl/cmdrst_pkg.sv
package cmdrst_pkg;

    localparam int OP_W   = 3;
    localparam int TYPE_W = 3;
    localparam int CMD_W  = OP_W + TYPE_W;

    localparam logic [TYPE_W-1:0] CT_RESET   = 3'b000;
    localparam logic [TYPE_W-1:0] CT_SELCFG  = 3'b001;
    localparam logic [TYPE_W-1:0] CT_DMADIR  = 3'b010;
    localparam logic [TYPE_W-1:0] CT_STATFMT = 3'b011;

    localparam logic [OP_W-1:0] RST_BA   = 3'b001;
    localparam logic [OP_W-1:0] RST_AB   = 3'b010;
    localparam logic [OP_W-1:0] RST_BOTH = 3'b011;
    localparam logic [OP_W-1:0] RST_DMA  = 3'b100;
    localparam logic [OP_W-1:0] RST_ALL  = 3'b111;

    localparam logic DIR_BA_WRITE = 1'b0;
    localparam logic FMT_ZERO     = 1'b0;

    typedef struct packed {
        logic            do_clr_ba;
        logic            do_clr_ab;
        logic            do_clr_dma;
        logic            do_restore;
        logic            do_sel;
        logic            do_dir;
        logic            do_fmt;
        logic [OP_W-1:0] op;
    } dec_t;

    typedef struct packed {
        logic            clr_ba;
        logic            clr_ab;
        logic            clr_dma;
        logic            hw_clr;
        logic            dma_dir;
        logic            stat_fmt;
        logic [OP_W-1:0] sel_idx;
    } ctl_t;

    localparam ctl_t CTL_HW_RESET = '{
        clr_ba:   1'b1,
        clr_ab:   1'b1,
        clr_dma:  1'b1,
        hw_clr:   1'b1,
        dma_dir:  DIR_BA_WRITE,
        stat_fmt: FMT_ZERO,
        sel_idx:  '0
    };

endpackage

// File: rtl/cmdrst_decode.sv
module cmdrst_decode
    import cmdrst_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             periph_mode,
    output dec_t             dec
);

    logic [TYPE_W-1:0] cmd_type;
    logic [OP_W-1:0]   cmd_op;

    assign cmd_type = cmd_word[CMD_W-1:OP_W];
    assign cmd_op   = cmd_word[OP_W-1:0];

    always_comb begin
        dec    = '0;
        dec.op = cmd_op;
        if (cmd_valid) begin
            case (cmd_type)
                CT_RESET: begin
                    case (cmd_op)
                        RST_BA:   dec.do_clr_ba = 1'b1;
                        RST_AB:   dec.do_clr_ab = 1'b1;
                        RST_BOTH: begin
                            dec.do_clr_ba = 1'b1;
                            dec.do_clr_ab = 1'b1;
                        end
                        RST_DMA:  dec.do_clr_dma = 1'b1;
                        RST_ALL: begin
                            dec.do_clr_ba  = 1'b1;
                            dec.do_clr_ab  = 1'b1;
                            dec.do_clr_dma = 1'b1;
                            dec.do_restore = 1'b1;
                        end
                        default: ;
                    endcase
                end
                CT_SELCFG:  dec.do_sel = 1'b1;
                CT_DMADIR:  dec.do_dir = periph_mode;
                CT_STATFMT: dec.do_fmt = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cmdrst_cfg_bank.sv
module cmdrst_cfg_bank #(
    parameter int          CFG_W   = 16,
    parameter int          N_CFG   = 8,
    parameter int          DEF_IDX = 4,
    parameter logic [15:0] DEF_VAL = 16'h6420
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restore,
    input  logic                     wr_en,
    input  logic [$clog2(N_CFG)-1:0] wr_idx,
    input  logic [CFG_W-1:0]         wr_data,
    input  logic [$clog2(N_CFG)-1:0] rd_idx,
    output logic [CFG_W-1:0]         rd_data
);

    localparam int IDX_W = $clog2(N_CFG);

    logic [CFG_W-1:0] regs_q [N_CFG];
    logic [CFG_W-1:0] regs_d [N_CFG];

    function automatic logic [CFG_W-1:0] dflt(input int idx);
        return (idx == DEF_IDX) ? CFG_W'(DEF_VAL) : '0;
    endfunction

    always_comb begin
        for (int i = 0; i < N_CFG; i++) begin
            regs_d[i] = regs_q[i];
            if (restore) begin
                regs_d[i] = dflt(i);
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                regs_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CFG; i++) regs_q[i] <= dflt(i);
        end else begin
            for (int i = 0; i < N_CFG; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rd_data = regs_q[rd_idx];

    // R6: a restore leaves the default-valued register holding its default
    p_restore_def_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (regs_q[DEF_IDX] == CFG_W'(DEF_VAL)));

    // R7: a write without restore lands in the addressed register
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restore) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/cmdrst_ctrl.sv
module cmdrst_ctrl
    import cmdrst_pkg::*;
#(
    parameter int          CFG_W   = 16,
    parameter int          DEF_IDX = 4,
    parameter logic [15:0] DEF_VAL = 16'h6420
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [5:0]       cmd_word,
    input  logic             periph_mode,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             clr_ba_ptr,
    output logic             clr_ab_ptr,
    output logic             clr_dma_req,
    output logic             hw_clr,
    output logic [2:0]       cfg_sel,
    output logic             dma_dir,
    output logic             stat_fmt,
    output logic [CFG_W-1:0] cfg_rdata
);

    localparam int N_CFG = 1 << OP_W;

    dec_t dec;
    ctl_t st_d, st_q;

    cmdrst_decode u_decode (
        .cmd_valid   (cmd_valid),
        .cmd_word    (cmd_word),
        .periph_mode (periph_mode),
        .dec         (dec)
    );

    always_comb begin
        st_d          = st_q;
        st_d.clr_ba   = dec.do_clr_ba;
        st_d.clr_ab   = dec.do_clr_ab;
        st_d.clr_dma  = dec.do_clr_dma;
        st_d.hw_clr   = 1'b0;
        if (dec.do_sel) st_d.sel_idx  = dec.op;
        if (dec.do_dir) st_d.dma_dir  = dec.op[0];
        if (dec.do_fmt) st_d.stat_fmt = dec.op[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTL_HW_RESET;
        else        st_q <= st_d;
    end

    cmdrst_cfg_bank #(
        .CFG_W   (CFG_W),
        .N_CFG   (N_CFG),
        .DEF_IDX (DEF_IDX),
        .DEF_VAL (DEF_VAL)
    ) u_cfg_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .restore (dec.do_restore),
        .wr_en   (cfg_wr),
        .wr_idx  (st_q.sel_idx),
        .wr_data (cfg_wdata),
        .rd_idx  (st_q.sel_idx),
        .rd_data (cfg_rdata)
    );

    assign clr_ba_ptr  = st_q.clr_ba;
    assign clr_ab_ptr  = st_q.clr_ab;
    assign clr_dma_req = st_q.clr_dma;
    assign hw_clr      = st_q.hw_clr;
    assign cfg_sel     = st_q.sel_idx;
    assign dma_dir     = st_q.dma_dir;
    assign stat_fmt    = st_q.stat_fmt;

    // R2: operand 001 clears only the BA pointers
    p_ba_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word == 6'b000001)
        |=> (clr_ba_ptr && !clr_ab_ptr && !clr_dma_req));

    // R3: operand 010 clears only the AB pointers
    p_ab_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word == 6'b000010)
        |=> (!clr_ba_ptr && clr_ab_ptr && !clr_dma_req));

    // R4: operand 100 clears only the DMA request logic
    p_dma_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word == 6'b000100)
        |=> (!clr_ba_ptr && !clr_ab_ptr && clr_dma_req));

    // R5: no-op reset operands leave everything quiet
    p_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_word == 6'b000000 || cmd_word == 6'b000101 ||
                       cmd_word == 6'b000110))
        |=> (!clr_ba_ptr && !clr_ab_ptr && !clr_dma_req &&
             $stable(cfg_sel) && $stable(dma_dir) && $stable(stat_fmt)));

    // R6: reset-all keeps direction, format and index, no hardware-only clear
    p_all_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word == 6'b000111)
        |=> (clr_ba_ptr && clr_ab_ptr && clr_dma_req && !hw_clr &&
             $stable(cfg_sel) && $stable(dma_dir) && $stable(stat_fmt)));

    // R8: direction command ignored outside peripheral mode
    p_dir_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[5:3] == 3'b010 && !periph_mode)
        |=> $stable(dma_dir));

    // R9: status format follows operand bit 0
    p_fmt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[5:3] == 3'b011)
        |=> (stat_fmt == $past(cmd_word[0])));

    // R10: the hardware-only clear is a single pulse after reset
    p_hw_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr |=> !hw_clr);

    // R11: unassigned command types do nothing
    p_undef_type_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[5])
        |=> (!clr_ba_ptr && !clr_ab_ptr && !clr_dma_req &&
             $stable(cfg_sel) && $stable(dma_dir) && $stable(stat_fmt)));

endmodule

// File: tb/test_cmdrst_ctrl.sv
`timescale 1ns/1ps
module test_cmdrst_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_word = '0;
    logic        periph_mode = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        clr_ba_ptr, clr_ab_ptr, clr_dma_req, hw_clr;
    logic [2:0]  cfg_sel;
    logic        dma_dir, stat_fmt;
    logic [15:0] cfg_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    cmdrst_ctrl i_cmdrst_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .periph_mode(periph_mode), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .clr_ba_ptr(clr_ba_ptr), .clr_ab_ptr(clr_ab_ptr), .clr_dma_req(clr_dma_req),
        .hw_clr(hw_clr), .cfg_sel(cfg_sel), .dma_dir(dma_dir), .stat_fmt(stat_fmt),
        .cfg_rdata(cfg_rdata)
    );

    // entry: [14:9] cmd, [8] periph, [7:5] strobes {ba,ab,dma}, [4] dir, [3] fmt, [2:0] sel
    localparam int NV = 15;
    localparam logic [14:0] VEC [NV] = '{
        {6'h01, 1'b0, 3'b100, 1'b0, 1'b0, 3'd0},
        {6'h02, 1'b0, 3'b010, 1'b0, 1'b0, 3'd0},
        {6'h03, 1'b0, 3'b110, 1'b0, 1'b0, 3'd0},
        {6'h04, 1'b0, 3'b001, 1'b0, 1'b0, 3'd0},
        {6'h00, 1'b0, 3'b000, 1'b0, 1'b0, 3'd0},
        {6'h05, 1'b0, 3'b000, 1'b0, 1'b0, 3'd0},
        {6'h06, 1'b0, 3'b000, 1'b0, 1'b0, 3'd0},
        {6'h0D, 1'b0, 3'b000, 1'b0, 1'b0, 3'd5},
        {6'h11, 1'b0, 3'b000, 1'b0, 1'b0, 3'd5},
        {6'h11, 1'b1, 3'b000, 1'b1, 1'b0, 3'd5},
        {6'h1F, 1'b0, 3'b000, 1'b1, 1'b1, 3'd5},
        {6'h27, 1'b1, 3'b000, 1'b1, 1'b1, 3'd5},
        {6'h07, 1'b0, 3'b111, 1'b1, 1'b1, 3'd5},
        {6'h16, 1'b1, 3'b000, 1'b0, 1'b1, 3'd5},
        {6'h18, 1'b0, 3'b000, 1'b0, 1'b0, 3'd5}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] w);
        case (w[5:3])
            3'b000: case (w[2:0])
                        3'b001: return "R2";
                        3'b010, 3'b011: return "R3";
                        3'b100: return "R4";
                        3'b111: return "R6";
                        default: return "R5";
                    endcase
            3'b001: return "R7";
            3'b010: return "R8";
            3'b011: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic issue(input logic [5:0] w, input logic pm);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_word = w; periph_mode = pm;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic write_cfg(input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R10: state while in hardware reset
        repeat (3) @(negedge clk);
        check("R10", "strobes in reset", {clr_ba_ptr, clr_ab_ptr, clr_dma_req, hw_clr}, 4'b1111);
        check("R10", "held state in reset", {cfg_sel, dma_dir, stat_fmt}, 5'b0);
        check("R10", "cfg0 in reset", cfg_rdata, 16'h0000);
        rst_n = 1'b1;
        #0.5;
        check("R10", "strobes until first edge", {clr_ba_ptr, clr_ab_ptr, clr_dma_req, hw_clr}, 4'b1111);
        @(negedge clk);
        check("R10", "strobes after first edge", {clr_ba_ptr, clr_ab_ptr, clr_dma_req, hw_clr}, 4'b0000);

        // R1: command word layout and one-cycle strobes across the table
        for (int i = 0; i < NV; i++) begin
            logic [14:0] v;
            string t;
            v = VEC[i];
            t = tag_of(v[14:9]);
            issue(v[14:9], v[8]);
            check(t, $sformatf("strobes vec %0d", i), {clr_ba_ptr, clr_ab_ptr, clr_dma_req}, v[7:5]);
            check(t, $sformatf("dir vec %0d", i), dma_dir, v[4]);
            check(t, $sformatf("fmt vec %0d", i), stat_fmt, v[3]);
            check(t, $sformatf("sel vec %0d", i), cfg_sel, v[2:0]);
            check(t, $sformatf("hw_clr vec %0d", i), hw_clr, 1'b0);
            @(negedge clk);
            check("R1", $sformatf("pulse ends vec %0d", i), {clr_ba_ptr, clr_ab_ptr, clr_dma_req}, 3'b000);
        end

        // R7 / R10: default readback, write and read
        issue(6'h0C, 1'b0);
        check("R10", "cfg4 default", cfg_rdata, 16'h6420);
        write_cfg(16'hBEEF);
        check("R7", "cfg4 written", cfg_rdata, 16'hBEEF);
        issue(6'h0A, 1'b0);
        check("R7", "sel 2", cfg_sel, 3'd2);
        check("R7", "cfg2 default", cfg_rdata, 16'h0000);
        write_cfg(16'h1234);
        check("R7", "cfg2 written", cfg_rdata, 16'h1234);

        // R6: reset-all restores config, keeps selection
        issue(6'h07, 1'b0);
        check("R6", "cfg2 restored", cfg_rdata, 16'h0000);
        check("R6", "sel kept", cfg_sel, 3'd2);
        check("R6", "no hw_clr", hw_clr, 1'b0);
        issue(6'h0C, 1'b0);
        check("R6", "cfg4 restored", cfg_rdata, 16'h6420);

        // R10: hardware reset after state was changed
        write_cfg(16'hA5A5);
        issue(6'h11, 1'b1);
        issue(6'h19, 1'b0);
        check("R8", "dir set", dma_dir, 1'b1);
        check("R9", "fmt set", stat_fmt, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        check("R10", "hw reset strobes", {clr_ba_ptr, clr_ab_ptr, clr_dma_req, hw_clr}, 4'b1111);
        check("R10", "hw reset held state", {cfg_sel, dma_dir, stat_fmt}, 5'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        issue(6'h0C, 1'b0);
        check("R10", "cfg4 default after hw reset", cfg_rdata, 16'h6420);

        done = 1;
        finish_run();
    end

endmodule